// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 64-bit memory address for a load or store in one pipeline stage. It takes a base register value, an index register value, two immediate fields and a handful of decoded controls. It returns three things: the address to put on the memory request, whether the base register must be updated, and the value to write back into it. The register file, the memory access itself and any alignment checking are outside the block.

Four addressing forms are supported:

- **Scaled unsigned offset:** the 12-bit immediate is multiplied by the access size.
- **Pre-update:** a signed 9-bit immediate is added to the base, and the new pointer is used at once.
- **Post-update:** the old pointer is used, and the pointer is then advanced by the signed 9-bit immediate.
- **Register offset:** a zero- or sign-extended, optionally shifted index is added to the base.

All results are registered. A result appears one clock after the request is presented with `in_valid` high.

Top module: `ls_addr_gen`

## Requirements
- R1: With `in_mode`=0 (scaled unsigned offset), `out_addr` = base + (imm12 << s), where s is the `in_size` code (0 byte, 1 halfword, 2 word, 3 doubleword). A doubleword request with imm12=0xFFF adds 0x7FF8; a word request with 0xFFF adds 0x3FFC.
- R2: With `in_mode`=1 (pre-update), `out_addr` and `out_wb_data` both equal base + sign-extended imm9, with no scaling by size, and `out_wb_en` is 1.
- R3: With `in_mode`=2 (post-update), `out_addr` equals the unmodified base, `out_wb_data` equals base + sign-extended imm9 (unscaled), and `out_wb_en` is 1.
- R4: With `in_mode`=3 (register offset), `out_addr` = base + (ext(index) << t). The `in_ext` code selects ext: 0 zero-extends index[31:0], 1 sign-extends index[31:0], and 2 and 3 use all 64 bits. t equals the `in_size` code when `in_shift` is 1, and 0 otherwise.
- R5: Modes 0 and 3 never raise `out_wb_en`; in those modes `out_wb_data` carries the same value as `out_addr`.
- R6: All sums are taken modulo 2^64 and any carry-out is dropped.
- R7: A request with `in_valid`=1 and a legal mode (0..3) raises `out_valid` exactly one clock later, together with its results.
- R8: A request with `in_valid`=1 and a mode code of 4..7 gives `out_valid`=0 and `out_wb_en`=0 one clock later, and leaves `out_addr` and `out_wb_data` unchanged.
- R9: During and right after reset, `out_valid` and `out_wb_en` are 0 and `out_addr` and `out_wb_data` are 0.
- R10: When `in_valid` is 0, all other inputs are ignored. One clock later `out_valid` and `out_wb_en` are 0 and `out_addr` and `out_wb_data` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_mode | input | 3 | Addressing form: 0 scaled, 1 pre-update, 2 post-update, 3 register offset |
| in_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_base | input | 64 | Base register value |
| in_index | input | 64 | Index register value |
| in_imm12 | input | 12 | Unsigned immediate for scaled mode |
| in_imm9 | input | 9 | Signed immediate for pre/post-update |
| in_ext | input | 2 | Index extend: 0 zero-ext 32, 1 sign-ext 32, 2/3 full 64 |
| in_shift | input | 1 | Shift the index left by the size code |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 64 | Effective access address |
| out_wb_en | output | 1 | Base writeback required |
| out_wb_data | output | 64 | Base writeback value |

## Verification
Every result leaves the block one clock after its request, so a fault is visible on the very next cycle.

- A wrong offset choice or wrong scaling appears on `out_addr` on that cycle.
- A swapped pre/post selection shows up as a mismatch between `out_addr` and `out_wb_data`.
- A stale or wrongly updated output register is exposed by idle cycles and rejected mode codes, because both outputs must then hold exactly the previous result.
- Extend, shift and wraparound faults are reached by directed vectors, then by a long run of mixed random requests.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

   typedef enum logic [2:0] {
      AM_SCALED = 3'd0,
      AM_PRE    = 3'd1,
      AM_POST   = 3'd2,
      AM_REGOFF = 3'd3
   } am_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } sz_e;

   typedef enum logic [1:0] {
      IX_ZEXT32 = 2'd0,
      IX_SEXT32 = 2'd1,
      IX_FULL   = 2'd2,
      IX_FULLS  = 2'd3
   } ix_e;

   localparam int unsigned MODE_W  = 3;
   localparam int unsigned SIZE_W  = 2;
   localparam int unsigned NUM_SZ  = 4;
   localparam int unsigned MAX_SH  = NUM_SZ - 1;

   function automatic logic mode_legal(input logic [MODE_W-1:0] m);
      return (m == AM_SCALED) || (m == AM_PRE) || (m == AM_POST) || (m == AM_REGOFF);
   endfunction

   function automatic logic mode_writes_base(input logic [MODE_W-1:0] m);
      return (m == AM_PRE) || (m == AM_POST);
   endfunction

endpackage

// File: rtl/agu_imm_unit.sv
module agu_imm_unit
   import ls_agu_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned UIMM_W = 12,
   parameter int unsigned SIMM_W = 9
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [UIMM_W-1:0] uimm_i,
   input  logic [SIMM_W-1:0] simm_i,
   output logic [ADDR_W-1:0] uoff_o,
   output logic [ADDR_W-1:0] soff_o
);

   localparam int unsigned UPAD = ADDR_W - UIMM_W;
   localparam int unsigned SPAD = ADDR_W - SIMM_W;

   if (UIMM_W + MAX_SH > ADDR_W) begin : g_bad_uimm
      $error("agu_imm_unit: scaled immediate does not fit ADDR_W");
   end
   if (SIMM_W < 2 || SIMM_W >= ADDR_W) begin : g_bad_simm
      $error("agu_imm_unit: SIMM_W out of range");
   end

   logic [ADDR_W-1:0] uimm_zx;
   logic [ADDR_W-1:0] scaled [NUM_SZ];

   assign uimm_zx = {{UPAD{1'b0}}, uimm_i};

   for (genvar s = 0; s < NUM_SZ; s++) begin : g_scale
      assign scaled[s] = uimm_zx << s;
   end

   always_comb begin
      uoff_o = scaled[0];
      for (int s = 1; s < NUM_SZ; s++) begin
         if (size_i == SIZE_W'(s)) uoff_o = scaled[s];
      end
   end

   assign soff_o = {{SPAD{simm_i[SIMM_W-1]}}, simm_i};

endmodule

// File: rtl/agu_index_unit.sv
module agu_index_unit
   import ls_agu_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned HALF_W = 32
) (
   input  logic [ADDR_W-1:0] index_i,
   input  logic [1:0]        ext_i,
   input  logic              shift_en_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [ADDR_W-1:0] off_o
);

   localparam int unsigned XPAD = ADDR_W - HALF_W;

   if (HALF_W == 0 || HALF_W >= ADDR_W) begin : g_bad_half
      $error("agu_index_unit: HALF_W must be below ADDR_W");
   end

   logic [ADDR_W-1:0] ext_val;
   logic [ADDR_W-1:0] shifted [NUM_SZ];
   logic [SIZE_W-1:0] amt;

   always_comb begin
      unique case (ext_i)
         IX_ZEXT32: ext_val = {{XPAD{1'b0}}, index_i[HALF_W-1:0]};
         IX_SEXT32: ext_val = {{XPAD{index_i[HALF_W-1]}}, index_i[HALF_W-1:0]};
         default:   ext_val = index_i;
      endcase
   end

   assign amt = shift_en_i ? size_i : '0;

   for (genvar s = 0; s < NUM_SZ; s++) begin : g_shift
      assign shifted[s] = ext_val << s;
   end

   always_comb begin
      off_o = shifted[0];
      for (int s = 1; s < NUM_SZ; s++) begin
         if (amt == SIZE_W'(s)) off_o = shifted[s];
      end
   end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
   parameter int unsigned ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              legal_i,
   input  logic              wb_req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] wb_i,
   output logic              valid_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ADDR_W-1:0] wb_o
);

   logic load;
   assign load = take_i & legal_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         wb_en_o <= 1'b0;
         addr_o  <= '0;
         wb_o    <= '0;
      end else begin
         valid_o <= load;
         wb_en_o <= load & wb_req_i;
         if (load) begin
            addr_o <= addr_i;
            wb_o   <= wb_i;
         end
      end
   end

   // R5: a writeback is only ever flagged on a valid result
   p_wb_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> valid_o);

   // R7: legal request yields a result next cycle
   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && legal_i) |=> valid_o);

   // R8: rejected codes keep outputs
   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !legal_i) |=> (!valid_o && !wb_en_o && $stable(addr_o) && $stable(wb_o)));

   // R10: idle cycles hold the result registers
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> (!valid_o && !wb_en_o && $stable(addr_o) && $stable(wb_o)));

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import ls_agu_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned UIMM_W = 12,
   parameter int unsigned SIMM_W = 9,
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_mode,
   input  logic [1:0]        in_size,
   input  logic [ADDR_W-1:0] in_base,
   input  logic [ADDR_W-1:0] in_index,
   input  logic [UIMM_W-1:0] in_imm12,
   input  logic [SIMM_W-1:0] in_imm9,
   input  logic [1:0]        in_ext,
   input  logic              in_shift,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_wb_en,
   output logic [ADDR_W-1:0] out_wb_data
);

   logic [ADDR_W-1:0] uoff, soff, xoff, offset, sum, addr_sel;
   logic              legal, wb_req;

   agu_imm_unit #(.ADDR_W(ADDR_W), .UIMM_W(UIMM_W), .SIMM_W(SIMM_W)) imm_i (
      .size_i (in_size),
      .uimm_i (in_imm12),
      .simm_i (in_imm9),
      .uoff_o (uoff),
      .soff_o (soff)
   );

   agu_index_unit #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) idx_i (
      .index_i    (in_index),
      .ext_i      (in_ext),
      .shift_en_i (in_shift),
      .size_i     (in_size),
      .off_o      (xoff)
   );

   assign legal  = mode_legal(in_mode);
   assign wb_req = mode_writes_base(in_mode);

   always_comb begin
      unique case (in_mode)
         AM_SCALED:        offset = uoff;
         AM_PRE, AM_POST:  offset = soff;
         AM_REGOFF:        offset = xoff;
         default:          offset = '0;
      endcase
   end

   assign sum      = in_base + offset;
   assign addr_sel = (in_mode == AM_POST) ? in_base : sum;

   agu_out_stage #(.ADDR_W(ADDR_W)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (in_valid),
      .legal_i  (legal),
      .wb_req_i (wb_req),
      .addr_i   (addr_sel),
      .wb_i     (sum),
      .valid_o  (out_valid),
      .wb_en_o  (out_wb_en),
      .addr_o   (out_addr),
      .wb_o     (out_wb_data)
   );

   // R2: pre-update drives the same value on bus and writeback
   p_pre_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == AM_PRE) |=> (out_wb_en && out_addr == out_wb_data));

   // R3: post-update puts the untouched base on the bus
   p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == AM_POST) |=> (out_wb_en && out_addr == $past(in_base)));

   // R5: scaled and register-offset forms never write back
   p_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_mode == AM_SCALED || in_mode == AM_REGOFF)) |=>
      (!out_wb_en && out_addr == out_wb_data));

endmodule

// File: tb/ls_addr_gen_tb.sv
`timescale 1ns/1ps
module ls_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_mode = '0;
   logic [1:0]  in_size = '0;
   logic [63:0] in_base = '0;
   logic [63:0] in_index = '0;
   logic [11:0] in_imm12 = '0;
   logic [8:0]  in_imm9 = '0;
   logic [1:0]  in_ext = '0;
   logic        in_shift = 1'b0;
   logic        out_valid, out_wb_en;
   logic [63:0] out_addr, out_wb_data;

   always #10 clk = ~clk;   // 50 MHz

   ls_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_size(in_size), .in_base(in_base), .in_index(in_index),
      .in_imm12(in_imm12), .in_imm9(in_imm9), .in_ext(in_ext),
      .in_shift(in_shift), .out_valid(out_valid), .out_addr(out_addr),
      .out_wb_en(out_wb_en), .out_wb_data(out_wb_data)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   bit running = 1'b0;

   logic        q_v[$];
   logic        q_w[$];
   logic [63:0] q_a[$];
   logic [63:0] q_d[$];
   string       q_tag[$];

   logic [63:0] m_addr = '0;
   logic [63:0] m_wb   = '0;

   function automatic logic [63:0] sx9(input logic [8:0] v);
      return {{55{v[8]}}, v};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic v, input logic [2:0] mode,
                        input logic [1:0] size, input logic [63:0] base,
                        input logic [63:0] idx, input logic [11:0] u12,
                        input logic [8:0] s9, input logic [1:0] ext, input logic sh);
      logic [63:0] off, xv, sum;
      logic ev, ew;
      @(negedge clk);
      in_valid = v; in_mode = mode; in_size = size; in_base = base;
      in_index = idx; in_imm12 = u12; in_imm9 = s9; in_ext = ext; in_shift = sh;
      ev = 1'b0; ew = 1'b0;
      if (v && mode <= 3'd3) begin
         ev = 1'b1;
         case (mode)
            3'd0: begin sum = base + ({52'd0, u12} << size); m_addr = sum; m_wb = sum; end
            3'd1: begin sum = base + sx9(s9); m_addr = sum; m_wb = sum; ew = 1'b1; end
            3'd2: begin sum = base + sx9(s9); m_addr = base; m_wb = sum; ew = 1'b1; end
            default: begin
               case (ext)
                  2'd0: xv = {32'd0, idx[31:0]};
                  2'd1: xv = {{32{idx[31]}}, idx[31:0]};
                  default: xv = idx;
               endcase
               off = xv << (sh ? size : 2'd0);
               sum = base + off; m_addr = sum; m_wb = sum;
            end
         endcase
      end
      q_v.push_back(ev); q_w.push_back(ew);
      q_a.push_back(m_addr); q_d.push_back(m_wb); q_tag.push_back(tag);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (running && q_v.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check(t, "out_valid",   {63'd0, out_valid}, {63'd0, q_v.pop_front()});
            check(t, "out_wb_en",   {63'd0, out_wb_en}, {63'd0, q_w.pop_front()});
            check(t, "out_addr",    out_addr,    q_a.pop_front());
            check(t, "out_wb_data", out_wb_data, q_d.pop_front());
         end
      end
   end

   // watchdog
   initial begin
      #(20 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R9", "out_valid",   {63'd0, out_valid}, 64'd0);
      check("R9", "out_wb_en",   {63'd0, out_wb_en}, 64'd0);
      check("R9", "out_addr",    out_addr, 64'd0);
      check("R9", "out_wb_data", out_wb_data, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;

      // R1 scaled immediate per size
      drive("R1", 1, 3'd0, 2'd3, 64'h1000_0000, 64'h0, 12'hFFF, 9'h0, 2'd0, 0);
      drive("R1", 1, 3'd0, 2'd2, 64'h1000_0000, 64'h0, 12'hFFF, 9'h0, 2'd0, 0);
      drive("R1", 1, 3'd0, 2'd1, 64'h2000, 64'h0, 12'h801, 9'h0, 2'd0, 0);
      drive("R1", 1, 3'd0, 2'd0, 64'h2000, 64'h0, 12'h123, 9'h1FF, 2'd0, 1);
      // R2 pre-update, negative and positive, size must not scale
      drive("R2", 1, 3'd1, 2'd3, 64'h8000, 64'h0, 12'hFFF, 9'h1F0, 2'd0, 1);
      drive("R2", 1, 3'd1, 2'd0, 64'h8000, 64'h0, 12'h0, 9'h0FF, 2'd0, 0);
      // R3 post-update
      drive("R3", 1, 3'd2, 2'd3, 64'h4000, 64'h0, 12'h0, 9'h008, 2'd0, 0);
      drive("R3", 1, 3'd2, 2'd2, 64'h4000, 64'h0, 12'h0, 9'h100, 2'd0, 1);
      // R4 register offset extend and shift options
      drive("R4", 1, 3'd3, 2'd3, 64'h100, 64'hFFFF_FFFF_8000_0004, 12'h0, 9'h0, 2'd0, 0);
      drive("R4", 1, 3'd3, 2'd3, 64'h100, 64'hFFFF_FFFF_8000_0004, 12'h0, 9'h0, 2'd1, 0);
      drive("R4", 1, 3'd3, 2'd3, 64'h100, 64'h0000_0001_0000_0010, 12'h0, 9'h0, 2'd2, 1);
      drive("R4", 1, 3'd3, 2'd1, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 9'h0, 2'd3, 1);
      drive("R4", 1, 3'd3, 2'd2, 64'h100, 64'h0000_0000_0000_0003, 12'h0, 9'h0, 2'd0, 1);
      // R5 no writeback in scaled / register forms right after a writeback
      drive("R5", 1, 3'd1, 2'd0, 64'h50, 64'h0, 12'h0, 9'h004, 2'd0, 0);
      drive("R5", 1, 3'd3, 2'd0, 64'h50, 64'h8, 12'h0, 9'h004, 2'd2, 0);
      drive("R5", 1, 3'd0, 2'd0, 64'h50, 64'h0, 12'h7, 9'h004, 2'd0, 0);
      // R6 wraparound
      drive("R6", 1, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 12'h004, 9'h0, 2'd0, 0);
      drive("R6", 1, 3'd1, 2'd0, 64'h0000_0000_0000_0004, 64'h0, 12'h0, 9'h1F0, 2'd0, 0);
      drive("R6", 1, 3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 12'h0, 9'h0, 2'd2, 0);
      // R8 rejected codes must not disturb outputs
      for (int m = 4; m < 8; m++)
         drive("R8", 1, 3'(m), 2'd3, 64'hDEAD_0000, 64'h1234, 12'h55, 9'h011, 2'd2, 1);
      // R10 idle cycles with busy inputs
      drive("R10", 0, 3'd1, 2'd3, 64'hAAAA_0000, 64'h99, 12'hFF, 9'h0AA, 2'd1, 1);
      drive("R10", 0, 3'd0, 2'd2, 64'hBBBB_0000, 64'h77, 12'h1, 9'h1AA, 2'd0, 0);
      // R7 back-to-back mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         drive("R7", (r[3:0] != 0), 3'(r[6:4] & 3'd3) | ((r[15:8] == 0) ? 3'd4 : 3'd0),
               r[8:7], {$urandom, $urandom}, {$urandom, $urandom},
               12'($urandom), 9'($urandom), r[10:9], r[11]);
      end
      drive("R10", 0, 3'd0, 2'd0, 64'h0, 64'h0, 12'h0, 9'h0, 2'd0, 0);
      repeat (3) @(posedge clk);
      #4;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule